// File: doc/BRIEF.md
# Instruction-Cache Invalidate-All Access Arbiter

This block sits between the system-instruction decoder and the instruction-cache controller. Each instruction arrives as one transfer on a valid/ready input: its encoding fields, the current exception level, and a set of hypervisor and secure-monitor control bits. The block checks whether the encoding is the "invalidate all instruction caches to the point of unification" operation. It then gives exactly one verdict for that instruction. The verdict is undefined, a trap to EL2 with a syndrome class, or an invalidate request. An invalidate request has either local or inner-shareable scope.

The verdict is registered and shows on the output one cycle after the input handshake. An invalidate request stays raised towards the cache controller until that controller takes it with `invReady`. While a request is outstanding the block holds off new input. Any encoding other than the recognised one is reported with `decMatched` low and has no other effect.

Top module: `sysinst_trap_chk`

## Requirements
- R1: The instruction is recognised only when op0=2'b01, op1=3'b000, crn=4'b0111, crm=4'b0101 and op2=3'b000. Any other encoding produces a `decValid` pulse with `decMatched`, `decUndef` and `trapValid` all 0, and raises no invalidate request.
- R2: When `curEl`=0 (EL0), a recognised instruction gives `decUndef`=1 and raises no invalidate request.
- R3: At `curEl`=1 with `el2Enabled`=1, the checks run in a fixed order: `trapPouMaint`, then `trapUnifMaint`, then the fine-grained trap. The first check that holds produces a trap, and a trap wins over `forceBroadcast`.
- R4: The fine-grained trap (`fgTrapIcAll`) counts only when `fgFeatureImpl`=1 and either `el3Impl`=0 or `el3FgEnable`=1. Otherwise the fine-grained check is skipped.
- R5: At `curEl`=1 with no trap, the invalidate scope depends on `forceBroadcast` and `el2Enabled`:
  - `el2Enabled`=1 and `forceBroadcast`=1 gives `invInner`=1 (inner-shareable).
  - Every other case gives local scope (`invInner`=0).
  - When `el2Enabled`=0, all hypervisor bits are ignored.
- R6: At `curEl`=2 or 3, a recognised instruction always raises a local-scope invalidate, whatever the trap and broadcast bits are.
- R7: The `rt` field does not change the verdict. A recognised instruction with `rt`≠5'b11111 sets the sticky `rtNonstd` flag, which only reset clears.
- R8: `decValid` pulses for one cycle, one cycle after an input handshake. Trap results are single-cycle pulses that coincide with `decValid`: `trapValid`=1, `trapTargetEl`=2 and `trapClass`=6'h18. Outside a trap, `trapTargetEl` and `trapClass` are 0.
- R9: Once raised, `invValid` stays high with `invInner` stable until a cycle in which `invReady` is 1. It drops after that cycle.
- R10: `inReady` is low whenever an invalidate request is pending, so no input is accepted during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction transfer valid |
| inReady | output | 1 | Block can accept an instruction |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| rt | input | 5 | Register operand index |
| curEl | input | 2 | Current exception level, 0 to 3 |
| el2Enabled | input | 1 | EL2 is enabled in the current state |
| trapPouMaint | input | 1 | Hypervisor trap of unification-point maintenance |
| trapUnifMaint | input | 1 | Hypervisor trap of cache-maintenance-to-unification |
| fgFeatureImpl | input | 1 | Fine-grained trap feature implemented |
| el3Impl | input | 1 | EL3 implemented |
| el3FgEnable | input | 1 | EL3 enable for fine-grained traps |
| fgTrapIcAll | input | 1 | Fine-grained trap bit for this instruction |
| forceBroadcast | input | 1 | Upgrade local maintenance to inner-shareable |
| decValid | output | 1 | Verdict strobe |
| decMatched | output | 1 | Encoding was recognised |
| decUndef | output | 1 | Verdict: undefined |
| trapValid | output | 1 | Verdict: trap to EL2 |
| trapTargetEl | output | 2 | Trap target level |
| trapClass | output | 6 | Trap syndrome class |
| invValid | output | 1 | Invalidate request to cache controller |
| invInner | output | 1 | 1 = inner-shareable scope, 0 = local |
| invReady | input | 1 | Cache controller accepts request |
| rtNonstd | output | 1 | Sticky: recognised instruction had rt≠31 |

## Verification
The bench targets the ordering of the trap chain. It sets all trap bits together with `forceBroadcast`: a design that tested the broadcast bit first would issue an inner-shareable invalidate here instead of trapping. It runs the fine-grained gating with EL3 present but disabled, so a design that ignored that gate would trap wrongly. It sets every hypervisor bit at EL2, at EL3 and with EL2 disabled; a design that applied the checks at the wrong level would trap or broadcast. It also stalls `invReady` while new input is offered, so a design that dropped the request or accepted input early would lose the request or emit a second `decValid`.

// File: rtl/sysinst_pkg.sv
package sysinst_pkg;
  localparam int EL_W    = 2;
  localparam int CLASS_W = 6;
  localparam int RT_W    = 5;

  localparam logic [1:0] ENC_OP0 = 2'b01;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0111;
  localparam logic [3:0] ENC_CRM = 4'b0101;
  localparam logic [2:0] ENC_OP2 = 3'b000;

  typedef enum logic [EL_W-1:0] {
    LVL_EL0 = 2'd0,
    LVL_EL1 = 2'd1,
    LVL_EL2 = 2'd2,
    LVL_EL3 = 2'd3
  } excLevel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;   // input handshake this cycle
  } ctlStrobe_t;

  // datapath -> control verdict summary
  typedef struct packed {
    logic wantInv;
    logic wantInner;
  } dpVerdict_t;
endpackage

// File: rtl/sysinst_decide_dp.sv
module sysinst_decide_dp
  import sysinst_pkg::*;
#(
  parameter int RT_ZERO = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        op0,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic [RT_W-1:0]   rt,
  input  logic [EL_W-1:0]   curEl,
  input  logic              el2Enabled,
  input  logic              trapPouMaint,
  input  logic              trapUnifMaint,
  input  logic              fgFeatureImpl,
  input  logic              el3Impl,
  input  logic              el3FgEnable,
  input  logic              fgTrapIcAll,
  input  logic              forceBroadcast,
  output dpVerdict_t        verdict,
  output logic              decMatched,
  output logic              decUndef,
  output logic              decTrap,
  output logic              decInv,
  output logic              invInner,
  output logic              rtNonstd
);
  localparam logic [RT_W-1:0] RT_DEFAULT = RT_W'(RT_ZERO);

  logic isMatch, fgActive, anyTrap, wantUndef, wantTrap;

  always_comb begin
    isMatch   = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
                (crm == ENC_CRM) && (op2 == ENC_OP2);
    fgActive  = fgFeatureImpl && (!el3Impl || el3FgEnable);
    anyTrap   = trapPouMaint || trapUnifMaint || (fgActive && fgTrapIcAll);
    wantUndef = 1'b0;
    wantTrap  = 1'b0;
    verdict   = '0;
    if (isMatch) begin
      unique case (excLevel_e'(curEl))
        LVL_EL0: wantUndef = 1'b1;
        LVL_EL1: begin
          if (el2Enabled && anyTrap) begin
            wantTrap = 1'b1;
          end else begin
            verdict.wantInv   = 1'b1;
            verdict.wantInner = el2Enabled && forceBroadcast;
          end
        end
        default: verdict.wantInv = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decMatched <= 1'b0;
      decUndef   <= 1'b0;
      decTrap    <= 1'b0;
      decInv     <= 1'b0;
      invInner   <= 1'b0;
      rtNonstd   <= 1'b0;
    end else begin
      decMatched <= strobe.load && isMatch;
      decUndef   <= strobe.load && wantUndef;
      decTrap    <= strobe.load && wantTrap;
      decInv     <= strobe.load && verdict.wantInv;
      if (strobe.load && verdict.wantInv) invInner <= verdict.wantInner;
      if (strobe.load && isMatch && (rt != RT_DEFAULT)) rtNonstd <= 1'b1;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    decMatched |-> $countones({decUndef, decTrap, decInv}) == 1);  // R3
  AST_UNMATCHED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decMatched |-> !decUndef && !decTrap && !decInv);  // R1
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && isMatch && curEl == 2'd0 |=> decUndef && !decInv);  // R2
  AST_HIGH_EL_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && isMatch && curEl[1] |=> decInv && !invInner);  // R6
  AST_STICKY_RT: assert property (@(posedge clk) disable iff (!rstN)
    rtNonstd |=> rtNonstd);  // R7
endmodule

// File: rtl/sysinst_hs_ctl.sv
module sysinst_hs_ctl
  import sysinst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       invReady,
  input  dpVerdict_t verdict,
  output logic       inReady,
  output logic       decValid,
  output logic       invValid,
  output ctlStrobe_t strobe
);
  always_comb begin
    inReady     = !invValid;
    strobe.load = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      invValid <= 1'b0;
    end else begin
      decValid <= strobe.load;
      if (strobe.load && verdict.wantInv) invValid <= 1'b1;
      else if (invValid && invReady)      invValid <= 1'b0;
    end
  end

  AST_DEC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> decValid);  // R8
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    invValid && !invReady |=> invValid);  // R9
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !inReady);  // R10
endmodule

// File: rtl/sysinst_trap_chk.sv
module sysinst_trap_chk
  import sysinst_pkg::*;
#(
  parameter int                TRAP_EL    = 2,
  parameter logic [CLASS_W-1:0] TRAP_CODE = 6'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic [4:0]         rt,
  input  logic [1:0]         curEl,
  input  logic               el2Enabled,
  input  logic               trapPouMaint,
  input  logic               trapUnifMaint,
  input  logic               fgFeatureImpl,
  input  logic               el3Impl,
  input  logic               el3FgEnable,
  input  logic               fgTrapIcAll,
  input  logic               forceBroadcast,
  output logic               decValid,
  output logic               decMatched,
  output logic               decUndef,
  output logic               trapValid,
  output logic [1:0]         trapTargetEl,
  output logic [5:0]         trapClass,
  output logic               invValid,
  output logic               invInner,
  input  logic               invReady,
  output logic               rtNonstd
);
  ctlStrobe_t strobe;
  dpVerdict_t verdict;
  logic       decTrap, decInv;

  sysinst_decide_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .rt(rt),
    .curEl(curEl), .el2Enabled(el2Enabled),
    .trapPouMaint(trapPouMaint), .trapUnifMaint(trapUnifMaint),
    .fgFeatureImpl(fgFeatureImpl), .el3Impl(el3Impl), .el3FgEnable(el3FgEnable),
    .fgTrapIcAll(fgTrapIcAll), .forceBroadcast(forceBroadcast),
    .verdict(verdict), .decMatched(decMatched), .decUndef(decUndef),
    .decTrap(decTrap), .decInv(decInv), .invInner(invInner), .rtNonstd(rtNonstd)
  );

  sysinst_hs_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .invReady(invReady),
    .verdict(verdict), .inReady(inReady), .decValid(decValid),
    .invValid(invValid), .strobe(strobe)
  );

  always_comb begin
    trapValid    = decTrap;
    trapTargetEl = decTrap ? EL_W'(TRAP_EL) : '0;
    trapClass    = decTrap ? TRAP_CODE : '0;
  end

  AST_TRAP_WITH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> decValid && decMatched);  // R8
  AST_INV_WITH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    decInv |-> invValid && !trapValid);  // R9
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);  // R8
endmodule

// File: tb/sysinst_trap_chk_bench.sv
module sysinst_trap_chk_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, invReady = 1'b0;
  logic [1:0] op0 = 2'b01;
  logic [2:0] op1 = 3'b000, op2 = 3'b000;
  logic [3:0] crn = 4'b0111, crm = 4'b0101;
  logic [4:0] rt = 5'd31;
  logic [1:0] curEl = 2'd1;
  logic el2Enabled = 0, trapPouMaint = 0, trapUnifMaint = 0, fgFeatureImpl = 0;
  logic el3Impl = 0, el3FgEnable = 0, fgTrapIcAll = 0, forceBroadcast = 0;
  logic inReady, decValid, decMatched, decUndef, trapValid, invValid, invInner, rtNonstd;
  logic [1:0] trapTargetEl;
  logic [5:0] trapClass;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysinst_trap_chk u_sysinst_trap_chk (.*);

  task automatic chk(string tag, int act, int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // flags: {forceBroadcast, fgTrapIcAll, el3FgEnable, el3Impl, fgFeatureImpl, trapUnifMaint, trapPouMaint}
  task automatic send(input logic [1:0] el, input logic en2, input logic [6:0] f,
                      input logic [4:0] rtv, input logic [2:0] o2);
    @(negedge clk);
    curEl = el; el2Enabled = en2; rt = rtv; op2 = o2;
    {forceBroadcast, fgTrapIcAll, el3FgEnable, el3Impl, fgFeatureImpl, trapUnifMaint, trapPouMaint} = f;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    if (invValid) begin
      invReady = 1'b1;
      @(negedge clk);
      invReady = 1'b0;
    end
  endtask

  // expect: kind 0=undef 1=trap 2=local inv 3=inner inv
  task automatic expectOutcome(string tag, int kind);
    chk({tag, " decValid"}, decValid, 1);
    chk({tag, " decMatched"}, decMatched, 1);
    chk({tag, " undef"}, decUndef, kind == 0);
    chk({tag, " trap"}, trapValid, kind == 1);
    chk({tag, " invValid"}, invValid, kind >= 2);
    if (kind == 1) begin
      chk({tag, " trapEl"}, trapTargetEl, 2);
      chk({tag, " trapClass"}, trapClass, 'h18);
    end
    if (kind >= 2) chk({tag, " scope"}, invInner, kind == 3);
    drain();
  endtask

  task automatic t_reset();
    chk("R10 reset inReady", inReady, 1);
    chk("R9 reset invValid", invValid, 0);
    chk("R8 reset decValid", decValid, 0);
    chk("R7 reset rtNonstd", rtNonstd, 0);
  endtask

  task automatic t_unmatched();
    send(2'd1, 1'b0, 7'b0, 5'd31, 3'b001);
    chk("R1 unmatched decValid", decValid, 1);
    chk("R1 unmatched decMatched", decMatched, 0);
    chk("R1 unmatched trap", trapValid, 0);
    chk("R1 unmatched undef", decUndef, 0);
    chk("R1 unmatched invValid", invValid, 0);
    op2 = 3'b000;
  endtask

  task automatic t_el0();
    send(2'd0, 1'b1, 7'b1111111, 5'd31, 3'b000);
    expectOutcome("R2 el0", 0);
  endtask

  task automatic t_priority();
    send(2'd1, 1'b1, 7'b1111111, 5'd31, 3'b000);
    expectOutcome("R3 all traps over broadcast", 1);
    send(2'd1, 1'b1, 7'b1000010, 5'd31, 3'b000);
    expectOutcome("R3 unif trap only", 1);
    send(2'd1, 1'b1, 7'b1100001, 5'd31, 3'b000);
    expectOutcome("R3 pou trap only", 1);
    @(negedge clk);
    chk("R8 trap pulse gone", trapValid, 0);
    chk("R8 class cleared", trapClass, 0);
    chk("R8 decValid single", decValid, 0);
  endtask

  task automatic t_fine();
    send(2'd1, 1'b1, 7'b0100100, 5'd31, 3'b000);
    expectOutcome("R4 fg no el3", 1);
    send(2'd1, 1'b1, 7'b0101100, 5'd31, 3'b000);
    expectOutcome("R4 fg el3 disabled", 2);
    send(2'd1, 1'b1, 7'b0111100, 5'd31, 3'b000);
    expectOutcome("R4 fg el3 enabled", 1);
    send(2'd1, 1'b1, 7'b0100000, 5'd31, 3'b000);
    expectOutcome("R4 fg feature absent", 2);
  endtask

  task automatic t_scope();
    send(2'd1, 1'b1, 7'b1000000, 5'd31, 3'b000);
    expectOutcome("R5 broadcast inner", 3);
    send(2'd1, 1'b0, 7'b1111111, 5'd31, 3'b000);
    expectOutcome("R5 el2 off local", 2);
    send(2'd1, 1'b1, 7'b0000000, 5'd31, 3'b000);
    expectOutcome("R5 plain local", 2);
  endtask

  task automatic t_high();
    send(2'd2, 1'b1, 7'b1111111, 5'd31, 3'b000);
    expectOutcome("R6 el2", 2);
    send(2'd3, 1'b1, 7'b1111111, 5'd31, 3'b000);
    expectOutcome("R6 el3", 2);
  endtask

  task automatic t_rt();
    chk("R7 flag before", rtNonstd, 0);
    send(2'd1, 1'b1, 7'b1000000, 5'd4, 3'b000);
    chk("R7 flag set", rtNonstd, 1);
    expectOutcome("R7 rt ignored", 3);
    send(2'd1, 1'b0, 7'b0, 5'd31, 3'b001);
    chk("R7 flag sticky", rtNonstd, 1);
  endtask

  task automatic t_hold();
    send(2'd2, 1'b0, 7'b0, 5'd31, 3'b000);
    chk("R9 raised", invValid, 1);
    @(negedge clk);
    inValid = 1'b1; op2 = 3'b001;
    chk("R10 inReady low", inReady, 0);
    repeat (3) @(negedge clk);
    chk("R9 held", invValid, 1);
    chk("R9 scope stable", invInner, 0);
    chk("R10 no accept", decValid, 0);
    inValid = 1'b0; op2 = 3'b000;
    invReady = 1'b1;
    @(negedge clk);
    invReady = 1'b0;
    chk("R9 released", invValid, 0);
    chk("R10 ready again", inReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unmatched();
    t_el0();
    t_priority();
    t_fine();
    t_scope();
    t_high();
    t_rt();
    t_hold();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule